// File: doc/BRIEF.md
# I2C Data-Line Shift Path

This block carries the serial data of one I2C-mode channel for a nine-bit frame. It works in step with strobes from a separate SCL generator, one for each falling edge and one for each rising edge. When a frame is started it sends eight data bits, most significant first, and then the acknowledge bit. Each bit is placed on the line after an SCL falling edge. On every SCL rising edge of the frame it samples the data line. After the ninth sample it presents a nine-bit receive word and a one-cycle valid strobe.

The receive word has two layouts. The native layout gives the eight data bits in word bits 7..0 and the acknowledge bit in bit 8. The split layout gives the first seven data bits in bits 6..0 and the eighth data bit in bit 8. In the split layout the partial word can be read after the eighth rising edge. When the clock-phase control is set, the split layout switches to the native arrangement once the ninth edge has passed.

The transmitted level can be held back by 0 or by 2 to 8 count-source ticks before it reaches the pin. A disable control releases the open-drain driver whatever the data. The level the line rests at while idle can be written only while the channel is disabled.

Top module: `sda_shift_path`

## Requirements
- R1: After a frame starts, each `scl_fall` strobe puts the next frame bit on the line. The order is tx_word[7] down to tx_word[0], then tx_word[8]. With `dly_sel`=0 the line level (`!sda_drive_low`) shows the bit in the cycle after the strobe and changes at no other time while the channel is enabled.
- R2: With `layout_split`=0, the nine bits sampled on the nine `scl_rise` strobes of a frame are stored with sample 1 in rx_word[7] down to sample 8 in rx_word[0], and sample 9 in rx_word[8].
- R3: With `layout_split`=1 and `clk_phase`=0, samples 1..7 go to rx_word[6:0] (sample 1 in bit 6), sample 8 goes to rx_word[8] and sample 9 goes to rx_word[7]. In split layout, the cycle after the eighth `scl_rise`, rx_word already holds samples 1..7 in bits 6..0, sample 8 in bit 8 and 0 in bit 7.
- R4: With `layout_split`=1 and `clk_phase`=1, the word presented after the ninth `scl_rise` uses the native arrangement of R2.
- R5: `rx_valid` is high for exactly one cycle, the cycle after the ninth `scl_rise` strobe of a frame. In that same cycle `busy` reads 0.
- R6: `dly_sel`=0 applies no delay, so the line level follows the frame bit directly.
- R7: A `dly_sel` value k from 1 to 7 delays a level change until k+1 `cnt_tick` pulses have passed since the bit was set.
- R8: In the cycle after `sda_off` is sampled high, `sda_drive_low` is 0 whatever the data.
- R9: A pulse on `idle_wr` while `chan_en`=0 loads `idle_val` as the idle line level, and the level appears on the line in the next cycle. A pulse on `idle_wr` while `chan_en`=1 has no effect.
- R10: `tx_load` starts a frame only when `chan_en`=1 and `busy`=0. A load while busy does not change the bits being sent.
- R11: After reset, `sda_drive_low`=0, `busy`=0, `rx_valid`=0, rx_word=0, and the idle level is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable |
| idle_wr | input | 1 | Idle-level write strobe (takes effect only while disabled) |
| idle_val | input | 1 | Idle line level to load |
| tx_word | input | DATA_W+1 | Transmit frame: data bits, with the acknowledge bit in the top bit |
| tx_load | input | 1 | Start-of-frame strobe |
| scl_rise | input | 1 | SCL rising-edge strobe |
| scl_fall | input | 1 | SCL falling-edge strobe |
| cnt_tick | input | 1 | Count-source tick for the output delay |
| dly_sel | input | SEL_W | Delay select: 0 means none, k means k+1 ticks |
| layout_split | input | 1 | Receive layout: 0 native, 1 split |
| clk_phase | input | 1 | Clock-phase control (split layout turns native at the end of the frame) |
| sda_off | input | 1 | Forces the data driver released |
| sda_in | input | 1 | Sampled data-line level |
| sda_drive_low | output | 1 | Open-drain pull-low enable |
| busy | output | 1 | Frame in progress |
| rx_word | output | DATA_W+1 | Formatted receive word |
| rx_valid | output | 1 | One-cycle strobe when rx_word is complete |

## Verification
A shift register that is off by one bit, or that fills from the wrong end, shows on the line within the first one or two falling edges of a frame. The same fault rotates the looped-back receive word, which can be seen in the cycle after the ninth rising edge. A wrong rise counter moves or doubles the valid strobe and leaves `busy` set past the frame. A wrong delay-line tap moves the level change by whole ticks, so sweeping every delay setting exposes it at the tick that does not match. A layout fault lands in the single cycle after the eighth or ninth sample, and every data word is swept in all three layout settings.

// File: rtl/sda_path_pkg.sv
package sda_path_pkg;

    typedef enum logic {
        LAYOUT_NATIVE = 1'b0,
        LAYOUT_SPLIT  = 1'b1
    } rx_layout_e;

    // Per-cycle frame events issued by the frame controller
    typedef struct packed {
        logic start;   // frame accepted
        logic cap;     // sample the line on this rising edge
        logic early;   // DATA_W-th sample of the frame
        logic last;    // final sample of the frame
    } frame_evt_t;

    // A zero select bypasses the delay line
    function automatic logic dly_bypass(input logic [7:0] sel);
        return (sel == 8'd0);
    endfunction

endpackage

// File: rtl/sda_frame_ctl.sv
module sda_frame_ctl
    import sda_path_pkg::*;
#(
    parameter int DATA_W  = 8,
    localparam int FRAME_W = DATA_W + 1,
    localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       chan_en,
    input  logic       tx_load,
    input  logic       scl_rise,
    output logic       busy,
    output frame_evt_t evt
);
    logic [CNT_W-1:0] rise_cnt;

    always_comb begin
        evt.start = tx_load && chan_en && !busy;
        evt.cap   = scl_rise && busy;
        evt.early = evt.cap && (rise_cnt == CNT_W'(DATA_W - 1));
        evt.last  = evt.cap && (rise_cnt == CNT_W'(FRAME_W - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            rise_cnt <= '0;
        end else if (!chan_en) begin
            busy     <= 1'b0;
            rise_cnt <= '0;
        end else if (evt.start) begin
            busy     <= 1'b1;
            rise_cnt <= '0;
        end else if (evt.cap) begin
            rise_cnt <= rise_cnt + 1'b1;
            if (evt.last) begin
                busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sda_tx_shift.sv
module sda_tx_shift
    import sda_path_pkg::*;
#(
    parameter int DATA_W  = 8,
    localparam int FRAME_W = DATA_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               chan_en,
    input  logic               idle_wr,
    input  logic               idle_val,
    input  logic [FRAME_W-1:0] tx_word,
    input  frame_evt_t         evt,
    input  logic               busy,
    input  logic               scl_fall,
    output logic               lvl
);
    logic [FRAME_W-1:0] sh;
    logic               idle_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '1;
            idle_q <= 1'b1;
            lvl    <= 1'b1;
        end else if (!chan_en) begin
            if (idle_wr) begin
                idle_q <= idle_val;
                lvl    <= idle_val;
            end else begin
                lvl    <= idle_q;
            end
        end else begin
            if (evt.start) begin
                // data bits first, acknowledge bit last
                sh <= {tx_word[DATA_W-1:0], tx_word[DATA_W]};
            end else if (scl_fall && busy) begin
                lvl <= sh[FRAME_W-1];
                sh  <= {sh[FRAME_W-2:0], 1'b1};
            end else if (scl_fall) begin
                lvl <= idle_q;
            end
        end
    end
endmodule

// File: rtl/sda_rx_shift.sv
module sda_rx_shift
    import sda_path_pkg::*;
#(
    parameter int DATA_W  = 8,
    localparam int FRAME_W = DATA_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  frame_evt_t         evt,
    input  logic               sda_in,
    input  rx_layout_e         layout,
    input  logic               clk_phase,
    output logic [FRAME_W-1:0] rx_word,
    output logic               rx_valid
);
    logic [FRAME_W-1:0] raw;
    logic [FRAME_W-1:0] raw_nxt;

    // samples are held oldest-first in the high bits
    function automatic logic [FRAME_W-1:0] fmt_native(input logic [FRAME_W-1:0] r);
        return {r[0], r[FRAME_W-1:1]};
    endfunction

    function automatic logic [FRAME_W-1:0] fmt_split(input logic [FRAME_W-1:0] r);
        return {r[1], r[0], r[FRAME_W-1:2]};
    endfunction

    function automatic logic [FRAME_W-1:0] fmt_partial(input logic [FRAME_W-1:0] r);
        return {r[0], 1'b0, r[DATA_W-1:1]};
    endfunction

    assign raw_nxt = {raw[FRAME_W-2:0], sda_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            raw      <= '0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= evt.last;
            if (evt.start) begin
                raw <= '0;
            end else if (evt.cap) begin
                raw <= raw_nxt;
            end
            if (evt.last) begin
                if (layout == LAYOUT_NATIVE || clk_phase) begin
                    rx_word <= fmt_native(raw_nxt);
                end else begin
                    rx_word <= fmt_split(raw_nxt);
                end
            end else if (evt.early && layout == LAYOUT_SPLIT) begin
                rx_word <= fmt_partial(raw_nxt);
            end
        end
    end
endmodule

// File: rtl/sda_out_delay.sv
module sda_out_delay
    import sda_path_pkg::*;
#(
    parameter int MAX_DLY = 8,
    localparam int SEL_W  = $clog2(MAX_DLY)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    input  logic             lvl_in,
    output logic             lvl_out
);
    logic [MAX_DLY-1:0] line;

    for (genvar i = 0; i < MAX_DLY; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)       line[i] <= 1'b1;
                else if (tick) line[i] <= lvl_in;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst)       line[i] <= 1'b1;
                else if (tick) line[i] <= line[i-1];
            end
        end
    end

    // select k taps stage k, which holds the level k+1 ticks old
    assign lvl_out = dly_bypass(8'(sel)) ? lvl_in : line[sel];
endmodule

// File: rtl/sda_shift_path.sv
module sda_shift_path
    import sda_path_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int MAX_DLY = 8,
    localparam int FRAME_W = DATA_W + 1,
    localparam int SEL_W   = $clog2(MAX_DLY)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               chan_en,
    input  logic               idle_wr,
    input  logic               idle_val,
    input  logic [FRAME_W-1:0] tx_word,
    input  logic               tx_load,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               cnt_tick,
    input  logic [SEL_W-1:0]   dly_sel,
    input  logic               layout_split,
    input  logic               clk_phase,
    input  logic               sda_off,
    input  logic               sda_in,
    output logic               sda_drive_low,
    output logic               busy,
    output logic [FRAME_W-1:0] rx_word,
    output logic               rx_valid
);
    frame_evt_t evt;
    logic       tx_lvl;
    logic       line_lvl;
    logic       off_q;

    sda_frame_ctl #(.DATA_W(DATA_W)) i_ctl (
        .clk      (clk),
        .rst      (rst),
        .chan_en  (chan_en),
        .tx_load  (tx_load),
        .scl_rise (scl_rise),
        .busy     (busy),
        .evt      (evt)
    );

    sda_tx_shift #(.DATA_W(DATA_W)) i_tx (
        .clk      (clk),
        .rst      (rst),
        .chan_en  (chan_en),
        .idle_wr  (idle_wr),
        .idle_val (idle_val),
        .tx_word  (tx_word),
        .evt      (evt),
        .busy     (busy),
        .scl_fall (scl_fall),
        .lvl      (tx_lvl)
    );

    sda_rx_shift #(.DATA_W(DATA_W)) i_rx (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .sda_in    (sda_in),
        .layout    (rx_layout_e'(layout_split)),
        .clk_phase (clk_phase),
        .rx_word   (rx_word),
        .rx_valid  (rx_valid)
    );

    sda_out_delay #(.MAX_DLY(MAX_DLY)) i_dly (
        .clk     (clk),
        .rst     (rst),
        .tick    (cnt_tick),
        .sel     (dly_sel),
        .lvl_in  (tx_lvl),
        .lvl_out (line_lvl)
    );

    // the disable control is taken on the system clock, never on an SCL edge
    always_ff @(posedge clk) begin
        if (rst) off_q <= sda_off;
        else     off_q <= sda_off;
    end

    assign sda_drive_low = !off_q && !line_lvl;
endmodule

// File: rtl/sda_shift_path_chk.sv
module sda_shift_path_chk #(
    parameter int SEL_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             chan_en,
    input logic             tx_load,
    input logic             scl_rise,
    input logic             scl_fall,
    input logic [SEL_W-1:0] dly_sel,
    input logic             sda_off,
    input logic             sda_drive_low,
    input logic             busy,
    input logic             rx_valid
);
    AST_LINE_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (dly_sel == '0 && $past(dly_sel) == '0 && $past(chan_en) && !$past(scl_fall)
         && !sda_off && !$past(sda_off) && !$past(sda_off, 2)) |-> $stable(sda_drive_low)); // R1

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid); // R5

    AST_VALID_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> ($past(scl_rise) && !busy)); // R5

    AST_BUSY_ENDS_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && $past(chan_en)) |-> $past(scl_rise)); // R5

    AST_OFF_RELEASES: assert property (@(posedge clk) disable iff (rst)
        $past(sda_off) |-> !sda_drive_low); // R8

    AST_START_NEEDS_LOAD: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(tx_load) && $past(chan_en))); // R10
endmodule

bind sda_shift_path sda_shift_path_chk i_chk (.*);

// File: tb/test_sda_shift_path.sv
module test_sda_shift_path;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 195000;

    logic       clk = 1'b0;
    logic       rst;
    logic       chan_en, idle_wr, idle_val, tx_load, scl_rise, scl_fall, cnt_tick;
    logic [8:0] tx_word;
    logic [2:0] dly_sel;
    logic       layout_split, clk_phase, sda_off;
    logic       sda_in;
    logic       sda_drive_low, busy, rx_valid;
    logic [8:0] rx_word;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign sda_in = !sda_drive_low;   // loopback of the open-drain line

    sda_shift_path i_sda_shift_path (
        .clk(clk), .rst(rst), .chan_en(chan_en), .idle_wr(idle_wr), .idle_val(idle_val),
        .tx_word(tx_word), .tx_load(tx_load), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .cnt_tick(cnt_tick), .dly_sel(dly_sel), .layout_split(layout_split),
        .clk_phase(clk_phase), .sda_off(sda_off), .sda_in(sda_in),
        .sda_drive_low(sda_drive_low), .busy(busy), .rx_word(rx_word), .rx_valid(rx_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; chan_en = 1'b0; idle_wr = 1'b0; idle_val = 1'b1; tx_load = 1'b0;
        scl_rise = 1'b0; scl_fall = 1'b0; cnt_tick = 1'b0; tx_word = '0; dly_sel = '0;
        layout_split = 1'b0; clk_phase = 1'b0; sda_off = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_load(input logic [8:0] w);
        tx_word = w; tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    task automatic pulse_fall();
        scl_fall = 1'b1; @(negedge clk); scl_fall = 1'b0;
    endtask

    task automatic pulse_rise();
        scl_rise = 1'b1; @(negedge clk); scl_rise = 1'b0;
    endtask

    task automatic pulse_tick();
        cnt_tick = 1'b1; @(negedge clk); cnt_tick = 1'b0;
    endtask

    function automatic logic [8:0] exp_final(input logic [8:0] w, input bit split, input bit cp);
        if (!split || cp) return w;
        return {w[0], w[8], w[7:1]};
    endfunction

    // one frame with loopback; mid_at < 0 means no extra load during the frame
    task automatic run_frame(input logic [8:0] w, input bit split, input bit cp,
                             input int mid_at, input logic [8:0] w2);
        logic [8:0] seen;
        logic [8:0] want;
        layout_split = split; clk_phase = cp;
        pulse_load(w);
        seen = '0;
        for (int b = 0; b < 9; b++) begin
            if (b == mid_at) pulse_load(w2);
            pulse_fall();
            seen = {seen[7:0], !sda_drive_low};
            pulse_rise();
            if (b == 7 && split) begin
                want = {w[0], 1'b0, w[7:1]};
                chk(rx_word == want, "R3 partial word", int'(rx_word), int'(want));
            end
        end
        want = {w[7:0], w[8]};
        chk(seen == want, (mid_at >= 0) ? "R10 line bits" : "R1 line bits", int'(seen), int'(want));
        want = exp_final(w, split, cp);
        chk(rx_valid && rx_word == want && !busy,
            !split ? "R2 rx word" : (cp ? "R4 rx word" : "R3 rx word"),
            int'({rx_valid, busy, rx_word}), int'({2'b10, want}));
        @(negedge clk);
        chk(!rx_valid, "R5 valid one cycle", int'(rx_valid), 0);
    endtask

    initial begin
        int first_err;
        do_reset();

        // R11 reset state
        chk(!sda_drive_low && !busy && !rx_valid && rx_word == '0, "R11 reset state",
            int'({sda_drive_low, busy, rx_valid, rx_word}), 0);

        // R9 idle load only while disabled
        idle_val = 1'b0; idle_wr = 1'b1; @(negedge clk); idle_wr = 1'b0;
        chk(sda_drive_low == 1'b1, "R9 idle load disabled", int'(sda_drive_low), 1);
        pulse_load(9'h000);
        chk(!busy, "R10 load while disabled", int'(busy), 0);
        chan_en = 1'b1; @(negedge clk);
        idle_val = 1'b1; idle_wr = 1'b1; @(negedge clk); idle_wr = 1'b0;
        @(negedge clk);
        chk(sda_drive_low == 1'b1, "R9 idle write ignored when enabled", int'(sda_drive_low), 1);

        // R1 R2 R3 R4 R5: sweep all words in all layout settings
        do_reset();
        chan_en = 1'b1; @(negedge clk);
        for (int cfg = 0; cfg < 3; cfg++) begin
            first_err = errors;
            for (int w = 0; w < 512; w++) begin
                run_frame(9'(w), cfg != 0, cfg == 2, -1, '0);
                if (errors - first_err > 8) break;
            end
        end

        // R10 load during a frame is ignored
        run_frame(9'h0A5, 1'b0, 1'b0, 3, 9'h15A);

        // R6 R7: delay sweep
        for (int s = 0; s < 8; s++) begin
            bit ok;
            int bad_k;
            do_reset();
            chan_en = 1'b1; dly_sel = 3'(s); @(negedge clk);
            pulse_load(9'h000);
            pulse_fall();
            ok = (sda_drive_low == (s == 0));
            bad_k = ok ? -1 : 0;
            for (int k = 1; k <= 8; k++) begin
                pulse_tick();
                if (sda_drive_low != (s == 0 || k >= s + 1)) begin
                    ok = 1'b0;
                    if (bad_k < 0) bad_k = k;
                end
            end
            chk(ok, (s == 0) ? "R6 no delay" : "R7 tick delay", bad_k, s);
        end

        // R8 forced release
        do_reset();
        chan_en = 1'b1; @(negedge clk);
        pulse_load(9'h000);
        pulse_fall();
        chk(sda_drive_low == 1'b1, "R8 driving before release", int'(sda_drive_low), 1);
        sda_off = 1'b1; @(negedge clk);
        chk(sda_drive_low == 1'b0, "R8 forced release", int'(sda_drive_low), 0);
        sda_off = 1'b0; @(negedge clk);
        chk(sda_drive_low == 1'b1, "R8 drive resumes", int'(sda_drive_low), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule